// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight token latches that two bus ports share in order to claim and release shared resources. It is kept apart from any memory array. A port reaches the bank by raising its semaphore select while its memory enable is low. It then names a token with the low three address bits. A write of data bit 0 either requests the token (0) or releases it and cancels any request (1). A read returns whether this port holds the token.

Every token has a request latch for each side. When a port asks for a token that the other side already holds, its request is remembered. The request is granted on the same clock edge that the holder releases the token. The two ports see ownership as complements: the holder reads 0 and the other port reads 1, and a free token reads 1 on both. Read data is copied onto every data bit and captured in a per-port output register, so a later write from the other side cannot change it. Both ports run on one clock.

Top module: `sem_bank`

## Requirements
- R1: The token is selected by address bits [2:0], giving eight tokens. Address bits above bit 2 have no effect on which token is used.
- R2: A port accesses the bank only when its semaphore select is 1 and its memory enable is 0. Any other combination leaves token state and that port's read data unchanged.
- R3: A write uses only data bit 0: 0 requests the token and 1 releases it. Data bits 15..1 are ignored.
- R4: A read returns 0 on every data bit to the port that holds the token, and 1 on every data bit to the other port. For a free token it returns 1 on every bit to both ports.
- R5: While one port holds a token, writes from the other port do not take ownership away from the holder.
- R6: If the non-holder has a pending request when the holder writes 1, the non-holder holds the token from the next clock on.
- R7: Read data appears on the port's data output one clock after the read. It reflects the token state before any write made in the same cycle. The output keeps its value until that port reads again.
- R8: After reset every token is free and both read-data outputs are all ones.
- R9: If both ports request the same free token in the same cycle, the left port gets it. The right request stays pending and is granted when the left port releases.
- R10: A non-holder that writes 1 cancels its pending request. A later release by the holder then leaves the token free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| left_sem_sel | input | 1 | Left semaphore select, active high |
| left_mem_en | input | 1 | Left memory enable; must be 0 for semaphore access |
| left_wr | input | 1 | Left write (1) or read (0) |
| left_addr | input | ADDR_W | Left address; bits [2:0] pick the token |
| left_wdata | input | DATA_W | Left write data; bit 0 used |
| left_rdata | output | DATA_W | Left registered read data |
| right_sem_sel | input | 1 | Right semaphore select, active high |
| right_mem_en | input | 1 | Right memory enable; must be 0 for semaphore access |
| right_wr | input | 1 | Right write (1) or read (0) |
| right_addr | input | ADDR_W | Right address; bits [2:0] pick the token |
| right_wdata | input | DATA_W | Right write data; bit 0 used |
| right_rdata | output | DATA_W | Right registered read data |

## Verification
The assertions rely on each port making at most one access per cycle, so no port both requests and releases the same token in a single cycle. They also assume the inputs are held steady across the clock edge. The bench drives every input on the falling edge and issues one read or one write per port per cycle, which keeps the stimulus inside those assumptions. It still covers same-cycle collisions from the two ports, including a release on one side in the same cycle as a read on the other.

// File: rtl/sem_bank_pkg.sv
// Shared types for the semaphore bank.
// Assumes: nothing beyond IEEE 1800-2017.
package sem_bank_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
// Turns one port's select, enable, direction, address and data bit 0
// into a read strobe, a token index and one-hot request/release strobes.
// Assumes: N_SEM == 2**IDX_W; higher address bits are ignored.
module sem_port_dec #(
    parameter int N_SEM = 8,
    parameter int IDX_W = 3
) (
    input  logic             sel,
    input  logic             mem_en,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic             wbit,
    output logic             rd_en,
    output logic [N_SEM-1:0] req,
    output logic [N_SEM-1:0] rel
);
    logic access;
    logic wr_en;

    // Purpose: qualify the access by select and inactive memory enable.
    always_comb begin
        access = sel & ~mem_en;
        rd_en  = access & ~wr;
        wr_en  = access & wr;
    end

    for (genvar i = 0; i < N_SEM; i++) begin : g_strobe
        // Purpose: per-token request and release strobes.
        always_comb begin
            req[i] = wr_en & (idx == IDX_W'(i)) & ~wbit;
            rel[i] = wr_en & (idx == IDX_W'(i)) &  wbit;
        end
    end
endmodule

// File: rtl/sem_cell.sv
// One token: a request latch per side plus an owner register.
// The holder keeps the token while its own request stays set.
// Otherwise the left request wins, then the right one.
// Assumes: a side never requests and releases in the same cycle.
module sem_cell
    import sem_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   l_req,
    input  logic   l_rel,
    input  logic   r_req,
    input  logic   r_rel,
    output owner_e owner,
    output logic   pend_l,
    output logic   pend_r
);
    logic   pend_l_nx;
    logic   pend_r_nx;
    owner_e owner_nx;

    // Purpose: update request latches from this cycle's writes.
    always_comb begin
        pend_l_nx = l_req ? 1'b1 : (l_rel ? 1'b0 : pend_l);
        pend_r_nx = r_req ? 1'b1 : (r_rel ? 1'b0 : pend_r);
    end

    // Purpose: keep the holder, else grant left first, then right.
    always_comb begin
        if (owner == OWN_LEFT && pend_l_nx)        owner_nx = OWN_LEFT;
        else if (owner == OWN_RIGHT && pend_r_nx)  owner_nx = OWN_RIGHT;
        else if (pend_l_nx)                        owner_nx = OWN_LEFT;
        else if (pend_r_nx)                        owner_nx = OWN_RIGHT;
        else                                       owner_nx = OWN_NONE;
    end

    // Purpose: state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l <= 1'b0;
            pend_r <= 1'b0;
            owner  <= OWN_NONE;
        end else begin
            pend_l <= pend_l_nx;
            pend_r <= pend_r_nx;
            owner  <= owner_nx;
        end
    end
endmodule

// File: rtl/sem_read_reg.sv
// Per-port read output register: copies the flag onto every data bit
// when the port reads and holds it otherwise.
// Assumes: flag is sampled from state before this cycle's writes.
module sem_read_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata
);
    // Purpose: capture the replicated flag on a read; reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '1;
        else if (rd_en) rdata <= {DATA_W{flag}};
    end
endmodule

// File: rtl/sem_bank.sv
// Two-port bank of N_SEM hardware semaphores on a single clock.
// Assumes: each port makes at most one access per cycle; DATA_W >= 2;
// ADDR_W > IDX_W.
module sem_bank
    import sem_bank_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int N_SEM  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_sem_sel,
    input  logic              left_mem_en,
    input  logic              left_wr,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic [DATA_W-1:0] left_wdata,
    output logic [DATA_W-1:0] left_rdata,
    input  logic              right_sem_sel,
    input  logic              right_mem_en,
    input  logic              right_wr,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic [DATA_W-1:0] right_wdata,
    output logic [DATA_W-1:0] right_rdata
);
    localparam int IDX_W = $clog2(N_SEM);

    logic [IDX_W-1:0] l_idx, r_idx;
    logic             l_rd_en, r_rd_en;
    logic [N_SEM-1:0] l_wr_req, l_wr_rel, r_wr_req, r_wr_rel;
    logic [N_SEM-1:0] own_l_vec, own_r_vec, pend_l_vec, pend_r_vec;
    owner_e           owner [N_SEM];
    logic             l_flag, r_flag;
    logic             unused_bits;

    // Purpose: pick token index bits; upper address and data bits unused.
    always_comb begin
        l_idx       = left_addr[IDX_W-1:0];
        r_idx       = right_addr[IDX_W-1:0];
        unused_bits = ^{left_addr[ADDR_W-1:IDX_W], right_addr[ADDR_W-1:IDX_W],
                        left_wdata[DATA_W-1:1], right_wdata[DATA_W-1:1]};
    end

    sem_port_dec #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_dec_l (
        .sel(left_sem_sel), .mem_en(left_mem_en), .wr(left_wr),
        .idx(l_idx), .wbit(left_wdata[0]),
        .rd_en(l_rd_en), .req(l_wr_req), .rel(l_wr_rel)
    );

    sem_port_dec #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_dec_r (
        .sel(right_sem_sel), .mem_en(right_mem_en), .wr(right_wr),
        .idx(r_idx), .wbit(right_wdata[0]),
        .rd_en(r_rd_en), .req(r_wr_req), .rel(r_wr_rel)
    );

    for (genvar i = 0; i < N_SEM; i++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_wr_req[i]), .l_rel(l_wr_rel[i]),
            .r_req(r_wr_req[i]), .r_rel(r_wr_rel[i]),
            .owner(owner[i]), .pend_l(pend_l_vec[i]), .pend_r(pend_r_vec[i])
        );

        // Purpose: per-side ownership view of this token.
        always_comb begin
            own_l_vec[i] = (owner[i] == OWN_LEFT);
            own_r_vec[i] = (owner[i] == OWN_RIGHT);
        end
    end

    // Purpose: complementary read flags; 0 means this side holds the token.
    always_comb begin
        l_flag = ~own_l_vec[l_idx];
        r_flag = ~own_r_vec[r_idx];
    end

    sem_read_reg #(.DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .flag(l_flag), .rdata(left_rdata)
    );

    sem_read_reg #(.DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .flag(r_flag), .rdata(right_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
// Property checker for sem_bank, attached by bind below.
// Assumes: one access per port per cycle.
module sem_bank_chk #(
    parameter int DATA_W = 16,
    parameter int N_SEM  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              left_sem_sel,
    input logic              left_mem_en,
    input logic              l_rd_en,
    input logic              r_rd_en,
    input logic [N_SEM-1:0]  l_wr_req,
    input logic [N_SEM-1:0]  l_wr_rel,
    input logic [N_SEM-1:0]  r_wr_req,
    input logic [N_SEM-1:0]  r_wr_rel,
    input logic [N_SEM-1:0]  own_l_vec,
    input logic [N_SEM-1:0]  own_r_vec,
    input logic [N_SEM-1:0]  pend_r_vec,
    input logic [DATA_W-1:0] left_rdata,
    input logic [DATA_W-1:0] right_rdata
);
    p_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_sem_sel && !left_mem_en) |-> (l_wr_req == '0 && l_wr_rel == '0 && !l_rd_en));

    p_flag_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd_en |=> (left_rdata == '0 || left_rdata == '1));

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd_en |=> $stable(right_rdata));

    p_reset_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (own_l_vec == '0 && own_r_vec == '0 && left_rdata == '1));

    for (genvar i = 0; i < N_SEM; i++) begin : g_tok
        p_keep_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
            own_l_vec[i] && !l_wr_rel[i] |=> own_l_vec[i]);

        p_keep_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
            own_r_vec[i] && !r_wr_rel[i] |=> own_r_vec[i]);

        p_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
            own_l_vec[i] && l_wr_rel[i] && pend_r_vec[i] && !r_wr_rel[i] |=> own_r_vec[i]);

        p_tie_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !own_l_vec[i] && !own_r_vec[i] && l_wr_req[i] |=> own_l_vec[i]);
    end
endmodule

bind sem_bank sem_bank_chk #(.DATA_W(DATA_W), .N_SEM(N_SEM)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .left_sem_sel(left_sem_sel), .left_mem_en(left_mem_en),
    .l_rd_en(l_rd_en), .r_rd_en(r_rd_en),
    .l_wr_req(l_wr_req), .l_wr_rel(l_wr_rel),
    .r_wr_req(r_wr_req), .r_wr_rel(r_wr_rel),
    .own_l_vec(own_l_vec), .own_r_vec(own_r_vec), .pend_r_vec(pend_r_vec),
    .left_rdata(left_rdata), .right_rdata(right_rdata)
);

// File: tb/sem_bank_test.sv
// Bench for sem_bank: a behavioural reference model steps with the
// design and both read outputs are compared every clock.
module sem_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ls = 0, lm = 0, lw = 0, rs = 0, rm = 0, rw = 0;
    logic [15:0] la = 0, ld = 0, ra = 0, rd = 0;
    logic [15:0] lq, rq;

    int checks = 0, fails = 0;
    bit done = 0;
    int own [8];      // 0 free, 1 left, 2 right
    bit want_l [8];
    bit want_r [8];
    bit exp_l = 1, exp_r = 1;

    always #2 clk = ~clk;

    sem_bank uut (
        .clk(clk), .rst_n(rst_n),
        .left_sem_sel(ls), .left_mem_en(lm), .left_wr(lw),
        .left_addr(la), .left_wdata(ld), .left_rdata(lq),
        .right_sem_sel(rs), .right_mem_en(rm), .right_wr(rw),
        .right_addr(ra), .right_wdata(rd), .right_rdata(rq)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive after a falling edge, advance the model, compare.
    task automatic step(string tag,
                        input logic s1, m1, w1, input logic [15:0] a1, d1,
                        input logic s2, m2, w2, input logic [15:0] a2, d2);
        int li, ri;
        ls = s1; lm = m1; lw = w1; la = a1; ld = d1;
        rs = s2; rm = m2; rw = w2; ra = a2; rd = d2;
        li = int'(a1 % 8);
        ri = int'(a2 % 8);
        if (s1 && !m1 && !w1) exp_l = (own[li] != 1);
        if (s2 && !m2 && !w2) exp_r = (own[ri] != 2);
        if (s1 && !m1 && w1) want_l[li] = !d1[0];
        if (s2 && !m2 && w2) want_r[ri] = !d2[0];
        foreach (own[i]) begin
            if (own[i] == 1 && want_l[i]) own[i] = 1;
            else if (own[i] == 2 && want_r[i]) own[i] = 2;
            else if (want_l[i]) own[i] = 1;
            else if (want_r[i]) own[i] = 2;
            else own[i] = 0;
        end
        @(negedge clk);
        check({tag, " left"},  lq, {16{exp_l}});
        check({tag, " right"}, rq, {16{exp_r}});
    endtask

    // Shorthands: one port acts, the other idles.
    task automatic lop(string tag, logic w, logic [15:0] a, logic [15:0] d);
        step(tag, 1, 0, w, a, d, 0, 0, 0, 0, 0);
    endtask
    task automatic rop(string tag, logic w, logic [15:0] a, logic [15:0] d);
        step(tag, 0, 0, 0, 0, 0, 1, 0, w, a, d);
    endtask

    initial begin
        foreach (own[i]) begin own[i] = 0; want_l[i] = 0; want_r[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R8 reset left", lq, 16'hFFFF);
        check("R8 reset right", rq, 16'hFFFF);
        lop("R8 free read", 0, 16'd3, 0);

        // R1, R4: request via an address with high bits set.
        lop("R1 left req 3", 1, 16'hA3A3, 16'h0000);
        lop("R4 left reads 3", 0, 16'h0003, 0);
        rop("R4 right reads 3", 0, 16'h7FF3, 0);

        // R5: right requests while left holds.
        rop("R5 right req 3", 1, 16'h0003, 16'h0000);
        rop("R5 right reads 3", 0, 16'h0003, 0);
        lop("R5 left reads 3", 0, 16'h0003, 0);

        // R6: release hands over to the pending right request.
        lop("R6 left rel 3", 1, 16'h0003, 16'h0001);
        rop("R6 right reads 3", 0, 16'h0003, 0);
        lop("R6 left reads 3", 0, 16'h0003, 0);
        rop("R6 right rel 3", 1, 16'h0003, 16'h0001);
        lop("R6 free read 3", 0, 16'h0003, 0);

        // R2: writes/reads with memory enable high or select low are ignored.
        step("R2 mem_en write", 1, 1, 1, 16'd5, 16'h0000, 0, 0, 0, 0, 0);
        step("R2 no sel write", 0, 0, 1, 16'd5, 16'h0000, 0, 0, 0, 0, 0);
        lop("R2 left reads 5", 0, 16'd5, 0);
        lop("R2 left req 5", 1, 16'd5, 16'h0000);
        step("R2 mem_en read holds", 1, 1, 0, 16'd5, 0, 0, 1, 0, 16'd5, 0);
        lop("R2 left reads 5 own", 0, 16'd5, 0);

        // R3: only bit 0 matters.
        lop("R3 rel 5 data FFFF", 1, 16'd5, 16'hFFFF);
        lop("R3 req 0 data FFFE", 1, 16'd0, 16'hFFFE);
        rop("R3 right reads 0", 0, 16'd0, 0);
        lop("R3 rel 0 data 0001", 1, 16'd0, 16'h0001);
        rop("R3 right reads 0 free", 0, 16'd0, 0);

        // R9: simultaneous request, left wins, right pends.
        step("R9 both req 6", 1, 0, 1, 16'd6, 16'h0, 1, 0, 1, 16'd6, 16'h0);
        step("R9 both read 6", 1, 0, 0, 16'd6, 0, 1, 0, 0, 16'd6, 0);
        lop("R9 left rel 6", 1, 16'd6, 16'h1);
        step("R9 both read 6 again", 1, 0, 0, 16'd6, 0, 1, 0, 0, 16'd6, 0);
        rop("R9 right rel 6", 1, 16'd6, 16'h1);

        // R10: cancelled request is not granted.
        lop("R10 left req 2", 1, 16'd2, 16'h0);
        rop("R10 right req 2", 1, 16'd2, 16'h0);
        rop("R10 right cancel 2", 1, 16'd2, 16'h1);
        lop("R10 left rel 2", 1, 16'd2, 16'h1);
        step("R10 both read 2", 1, 0, 0, 16'd2, 0, 1, 0, 0, 16'd2, 0);

        // R7: read sees state before a same-cycle write; output then holds.
        lop("R7 left req 4", 1, 16'd4, 16'h0);
        rop("R7 right req 4", 1, 16'd4, 16'h0);
        step("R7 rel while read", 1, 0, 1, 16'd4, 16'h1, 1, 0, 0, 16'd4, 0);
        step("R7 idle hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rop("R7 right reads 4", 0, 16'd4, 0);
        rop("R7 right rel 4", 1, 16'd4, 16'h1);

        // R1: all eight tokens, split by parity.
        for (int i = 0; i < 8; i++)
            step("R1 split req", 1, 0, i % 2 == 0, 16'(i), 16'h0,
                 1, 0, i % 2 == 1, 16'(i), 16'h0);
        for (int i = 0; i < 8; i++)
            step("R1 sweep read", 1, 0, 0, 16'(i + 8), 0, 1, 0, 0, 16'(i + 16), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule